// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a register-mapped watchdog for a system controller. A down-counter runs on a slow timebase, supplied here as a one-cycle `tick_en` strobe with a nominal period of 0.6 s, so a count of N ticks is N x 6/10 seconds. Software keeps it alive by writing the reload register, which puts the counter back to a programmable initial value. If software stops doing that, the watchdog escalates in two stages.

The first run-out only records a status flag and, when enabled, raises a level interrupt. The counter reloads on the same tick and runs a full second period. If it runs out again while the first flag is still set, the block records a second-timeout flag. It then issues a one-cycle reset request, unless a reboot-inhibit bit is set. After the second stage the counter stays frozen until software clears the second-timeout flag.

All registers are 16 bits wide on a simple synchronous bus with a write strobe, a word address, write data and two byte enables. Reads are combinational. After reset the watchdog is halted and reboots are inhibited, so it does nothing until software configures it.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the registers read as follows: word 0 reads 50, word 1 reads 50, words 2 and 3 read 0, word 4 reads 0x0800 and word 6 reads 0x0001. After reset `irq` and `rst_req` are 0.
- R2: The counter value reads back in bits 9:0 of word 0. It drops by exactly one on each cycle with `tick_en` high while it runs, and it never leaves the range 1..initial value.
- R3: A write to word 0 reloads the counter from the initial value, whatever the data and byte enables. A reload wins over a tick in the same cycle.
- R4: The 10-bit initial value sits in bits 9:0 of word 1. A write changes only the bytes whose enable is set: bits 7:0 follow `bus_be[0]` and bits 9:8 follow `bus_be[1]`. Bits 15:10 always read as 0.
- R5: A write to word 1 whose merged 10-bit value is 0, 1, 2 or 3 is ignored, and the previous initial value stays.
- R6: Bit 11 of word 4 is the halt bit and reads back as written. While it is 1, ticks do not change the counter.
- R7: The first expiry happens on the tick that finds the counter at 1 while the first flag (word 2 bit 3) is clear, so it comes N ticks after a reload to N. It sets the first flag and reloads the counter to N on that same tick. `irq` is high while the first flag is set and the enable (word 5 bit 13) is 1.
- R8: An expiry while the first flag is set is a second expiry. It sets the second-timeout flag (word 3 bit 1). If reboot is not inhibited, `rst_req` pulses high for exactly one cycle, in the cycle after the expiring tick, and the boot flag (word 3 bit 2) is set.
- R9: While the reboot-inhibit bit (word 6 bit 0) is 1, a second expiry still sets the second-timeout flag but gives no `rst_req` pulse and leaves the boot flag clear. Writing it to 0 reads back 0.
- R10: Writing 1 to any status flag clears it, writing 0 leaves it, and the write counts only when `bus_be[0]` is set. If an expiry sets a flag in the same cycle, the set wins.
- R11: While the second-timeout flag is set, the counter is frozen. Clearing that flag lets it count again on the next tick.
- R12: If the first flag is cleared before the counter runs out again, the next expiry counts as a first expiry again. The second-timeout flag stays 0 and no reset request is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte enables for the write |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| tick_en | input | 1 | One-cycle strobe for the timebase tick |
| irq | output | 1 | Level interrupt, first stage |
| rst_req | output | 1 | One-cycle reset request, second stage |

## Verification
The hardest state to reach from the ports is the window after a second expiry. Getting there takes a legal initial value, a reload, clearing the halt bit and then exactly 2N ticks with no reload in between. The bench sweeps N from 4 to 12, mixing the interrupt enable and the reboot inhibit across those values. For each N it checks the counter after every tick against N minus the number of ticks so far. At the second expiry it checks the pulse, the flags, and that the counter stays frozen until the flag is cleared.

// File: rtl/wdt_pkg.sv
// Package: shared widths, register word addresses and bit positions for the
// two-stage watchdog. Bit positions are the ones software decodes.
package wdt_pkg;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 3;
    localparam int BE_W     = DATA_W / 8;

    localparam logic [ADDR_W-1:0] A_RELOAD  = 3'd0;
    localparam logic [ADDR_W-1:0] A_INIT    = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT1   = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT2   = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd4;
    localparam logic [ADDR_W-1:0] A_IRQEN   = 3'd5;
    localparam logic [ADDR_W-1:0] A_INHIBIT = 3'd6;

    localparam int HALT_BIT    = 11;
    localparam int FIRST_BIT   = 3;
    localparam int SECOND_BIT  = 1;
    localparam int BOOT_BIT    = 2;
    localparam int IRQEN_BIT   = 13;
    localparam int INHIBIT_BIT = 0;

    localparam int MIN_INIT    = 4;
endpackage

// File: rtl/wdt_regs.sv
// Register file and read mux. Assumes single-cycle writes qualified by
// bus_wr; reads are combinational on bus_addr. Issues one-cycle strobes
// for reload and status clears; rejects illegal initial values.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int              CNT_W    = 10,
    parameter logic [CNT_W-1:0] RST_INIT = 10'd50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [BE_W-1:0]   bus_be,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              first_flag,
    input  logic              second_flag,
    input  logic              boot_flag,
    output logic [CNT_W-1:0]  init_val,
    output logic              halt,
    output logic              irq_en,
    output logic              inhibit,
    output logic              reload,
    output logic              clr_first,
    output logic              clr_second,
    output logic              clr_boot
);
    logic [CNT_W-1:0] init_merge;
    logic             wr_init, wr_ctrl, wr_irqen, wr_inh, wr_s1, wr_s2;

    // Decode which register a write targets.
    always_comb begin
        wr_init  = bus_wr && (bus_addr == A_INIT);
        wr_ctrl  = bus_wr && (bus_addr == A_CTRL)    && bus_be[HALT_BIT/8];
        wr_irqen = bus_wr && (bus_addr == A_IRQEN)   && bus_be[IRQEN_BIT/8];
        wr_inh   = bus_wr && (bus_addr == A_INHIBIT) && bus_be[INHIBIT_BIT/8];
        wr_s1    = bus_wr && (bus_addr == A_STAT1)   && bus_be[FIRST_BIT/8];
        wr_s2    = bus_wr && (bus_addr == A_STAT2);
    end

    // Merge the write data into the initial value, byte by byte.
    always_comb begin
        for (int i = 0; i < CNT_W; i++)
            init_merge[i] = bus_be[i/8] ? bus_wdata[i] : init_val[i];
    end

    // Strobes: reload on any write to word 0; write-one-to-clear status.
    always_comb begin
        reload     = bus_wr && (bus_addr == A_RELOAD);
        clr_first  = wr_s1 && bus_wdata[FIRST_BIT];
        clr_second = wr_s2 && bus_be[SECOND_BIT/8] && bus_wdata[SECOND_BIT];
        clr_boot   = wr_s2 && bus_be[BOOT_BIT/8]   && bus_wdata[BOOT_BIT];
    end

    // Storage for the configuration bits; a too-small initial value is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_val <= RST_INIT;
            halt     <= 1'b1;
            irq_en   <= 1'b0;
            inhibit  <= 1'b1;
        end else begin
            if (wr_init && (init_merge >= CNT_W'(MIN_INIT)))
                init_val <= init_merge;
            if (wr_ctrl)
                halt <= bus_wdata[HALT_BIT];
            if (wr_irqen)
                irq_en <= bus_wdata[IRQEN_BIT];
            if (wr_inh)
                inhibit <= bus_wdata[INHIBIT_BIT];
        end
    end

    // Read mux; unused bits and words read as zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_RELOAD:  bus_rdata[CNT_W-1:0]   = count;
            A_INIT:    bus_rdata[CNT_W-1:0]   = init_val;
            A_STAT1:   bus_rdata[FIRST_BIT]   = first_flag;
            A_STAT2: begin
                bus_rdata[SECOND_BIT] = second_flag;
                bus_rdata[BOOT_BIT]   = boot_flag;
            end
            A_CTRL:    bus_rdata[HALT_BIT]    = halt;
            A_IRQEN:   bus_rdata[IRQEN_BIT]   = irq_en;
            A_INHIBIT: bus_rdata[INHIBIT_BIT] = inhibit;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_counter.sv
// Down-counter. Assumes init_val is never below the legal minimum. Counts on
// tick while run is high; on the tick that finds 1 it flags expiry and
// reloads in the same cycle. A reload request wins over a tick.
module wdt_counter #(
    parameter int               CNT_W    = 10,
    parameter logic [CNT_W-1:0] RST_INIT = 10'd50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             reload,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    // Expiry: a counted tick at the bottom of the range, not masked by reload.
    always_comb expire = tick && run && !reload && (count <= CNT_W'(1));

    // Count register: reload, wrap on expiry, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= RST_INIT;
        else if (reload || expire)
            count <= init_val;
        else if (tick && run)
            count <= count - CNT_W'(1);
    end
endmodule

// File: rtl/wdt_stage.sv
// Escalation logic. The first expiry sets the first flag. An expiry with the
// flag already set sets the second flag and, unless inhibited, the boot flag
// and a one-cycle reset request. Clears arrive as one-cycle strobes; a set
// in the same cycle wins.
module wdt_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic inhibit,
    input  logic clr_first,
    input  logic clr_second,
    input  logic clr_boot,
    output logic first_flag,
    output logic second_flag,
    output logic boot_flag,
    output logic rst_req
);
    logic second_hit;

    // A second expiry is one that finds the first flag still set.
    always_comb second_hit = expire && first_flag;

    // Status flags and the registered reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_flag  <= 1'b0;
            second_flag <= 1'b0;
            boot_flag   <= 1'b0;
            rst_req     <= 1'b0;
        end else begin
            if (clr_first)                first_flag  <= 1'b0;
            if (expire && !first_flag)    first_flag  <= 1'b1;
            if (clr_second)               second_flag <= 1'b0;
            if (second_hit)               second_flag <= 1'b1;
            if (clr_boot)                 boot_flag   <= 1'b0;
            if (second_hit && !inhibit)   boot_flag   <= 1'b1;
            rst_req <= second_hit && !inhibit;
        end
    end
endmodule

// File: rtl/wdt_two_stage.sv
// Top level: ties the register file, counter and escalation stage together.
// The counter runs only when not halted and not frozen by a second timeout.
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int               CNT_W    = 10,
    parameter logic [CNT_W-1:0] RST_INIT = 10'd50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic [1:0]        bus_be,
    output logic [15:0]       bus_rdata,
    input  logic              tick_en,
    output logic              irq,
    output logic              rst_req
);
    logic [CNT_W-1:0] count, init_val;
    logic halt, irq_en, inhibit_q, reload;
    logic clr_first, clr_second, clr_boot;
    logic first_flag, second_flag, boot_flag;
    logic expire, run;

    // Run gate and interrupt level.
    always_comb begin
        run = !halt && !second_flag;
        irq = first_flag && irq_en;
    end

    wdt_regs #(.CNT_W(CNT_W), .RST_INIT(RST_INIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .count(count), .first_flag(first_flag), .second_flag(second_flag),
        .boot_flag(boot_flag), .init_val(init_val), .halt(halt),
        .irq_en(irq_en), .inhibit(inhibit_q), .reload(reload),
        .clr_first(clr_first), .clr_second(clr_second), .clr_boot(clr_boot)
    );

    wdt_counter #(.CNT_W(CNT_W), .RST_INIT(RST_INIT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .run(run), .reload(reload),
        .init_val(init_val), .count(count), .expire(expire)
    );

    wdt_stage u_stage (
        .clk(clk), .rst_n(rst_n), .expire(expire), .inhibit(inhibit_q),
        .clr_first(clr_first), .clr_second(clr_second), .clr_boot(clr_boot),
        .first_flag(first_flag), .second_flag(second_flag),
        .boot_flag(boot_flag), .rst_req(rst_req)
    );
endmodule

// File: rtl/wdt_checker.sv
// Checker for wdt_two_stage, attached by bind. Watches the counter, the
// flags and the reset request over time.
module wdt_checker #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_req,
    input logic             inhibit,
    input logic             first_flag,
    input logic             second_flag,
    input logic             halt,
    input logic             reload,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] init_val
);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    a_r9_inhibit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(inhibit));

    a_r8_second_after_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(second_flag) |-> $past(first_flag));

    a_r6_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload) |=> $stable(count));

    a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (second_flag && !reload) |=> $stable(count));

    a_r2_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        count != '0);

    a_r5_init_legal: assert property (@(posedge clk) disable iff (!rst_n)
        init_val >= CNT_W'(4));
endmodule

bind wdt_two_stage wdt_checker #(.CNT_W(CNT_W)) u_wdt_checker (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .inhibit(inhibit_q),
    .first_flag(first_flag), .second_flag(second_flag), .halt(halt),
    .reload(reload), .count(count), .init_val(init_val)
);

// File: tb/tb_wdt_two_stage.sv
module tb_wdt_two_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        irq, rst_req;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int pulses = 0;

    always #5 clk = ~clk;

    wdt_two_stage dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .irq(irq), .rst_req(rst_req)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && rst_req) pulses <= pulses + 1;
        if (cycles == 150000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: run hung, act=%0d exp=<150000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    // Halt, clear status, program N, reload, set enables, start.
    task automatic setup(input int n, input bit en, input bit inh);
        wr(3'd4, 16'h0800, 2'b11);
        wr(3'd2, 16'h0008, 2'b11);
        wr(3'd3, 16'h0006, 2'b11);
        wr(3'd1, 16'(n), 2'b11);
        wr(3'd5, en ? 16'h2000 : 16'h0000, 2'b11);
        wr(3'd6, inh ? 16'h0001 : 16'h0000, 2'b11);
        wr(3'd0, 16'h0000, 2'b00);
        wr(3'd4, 16'h0000, 2'b11);
    endtask

    initial begin
        logic [15:0] v;
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); chk("R1 count", v, 50);
        rd(3'd1, v); chk("R1 init", v, 50);
        rd(3'd2, v); chk("R1 stat1", v, 0);
        rd(3'd3, v); chk("R1 stat2", v, 0);
        rd(3'd4, v); chk("R1 halt", v, 16'h0800);
        rd(3'd6, v); chk("R1 inhibit", v, 1);
        chk("R1 irq", irq, 0);
        chk("R1 rst_req", rst_req, 0);

        // R6 halted: ticks do nothing
        repeat (3) tick();
        rd(3'd0, v); chk("R6 halted count", v, 50);

        // R4 byte enables and upper bits, R5 illegal values
        wr(3'd1, 16'hFC07, 2'b11); rd(3'd1, v); chk("R4 upper bits", v, 16'h0007);
        wr(3'd1, 16'h0305, 2'b01); rd(3'd1, v); chk("R4 low byte only", v, 16'h0005);
        wr(3'd1, 16'h0299, 2'b10); rd(3'd1, v); chk("R4 high byte only", v, 16'h0205);
        wr(3'd1, 16'h0003, 2'b11); rd(3'd1, v); chk("R5 value 3 ignored", v, 16'h0205);
        wr(3'd1, 16'h0000, 2'b11); rd(3'd1, v); chk("R5 value 0 ignored", v, 16'h0205);
        wr(3'd1, 16'h0004, 2'b11); rd(3'd1, v); chk("R5 value 4 accepted", v, 16'h0004);

        // R6 readback of halt, R9 inhibit readback
        wr(3'd4, 16'h0000, 2'b11); rd(3'd4, v); chk("R6 halt cleared", v, 0);
        wr(3'd6, 16'h0000, 2'b01); rd(3'd6, v); chk("R9 inhibit cleared", v, 0);

        // R3 reload mid count, and reload wins over same-cycle tick
        setup(9, 0, 1);
        repeat (4) tick();
        rd(3'd0, v); chk("R2 count after 4", v, 5);
        wr(3'd0, 16'h0000, 2'b00);
        rd(3'd0, v); chk("R3 reload", v, 9);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd0; tick_en = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
        rd(3'd0, v); chk("R3 reload beats tick", v, 9);

        // Sweep N = 4..12: full two-stage escalation
        for (int n = 4; n <= 12; n++) begin
            bit en, inh;
            en  = (n % 2) == 0;
            inh = (n % 3) == 0;
            setup(n, en, inh);
            rd(3'd0, v); chk("R3 start", v, n);
            for (int k = 1; k < n; k++) begin
                tick();
                rd(3'd0, v); chk("R2 countdown", v, n - k);
            end
            tick();
            rd(3'd2, v); chk("R7 first flag", v, 16'h0008);
            rd(3'd0, v); chk("R7 reload on expiry", v, n);
            chk("R7 irq gating", irq, en);
            chk("R7 no reset first", rst_req, 0);
            p0 = pulses;
            for (int k = 1; k < n; k++) tick();
            rd(3'd3, v); chk("R8 no early second", v, 0);
            tick();
            chk(inh ? "R9 no pulse" : "R8 pulse", rst_req, !inh);
            rd(3'd3, v); chk(inh ? "R9 flags" : "R8 flags", v, inh ? 16'h0002 : 16'h0006);
            @(negedge clk);
            chk("R8 pulse width", rst_req, 0);
            chk("R8 pulse count", pulses - p0, inh ? 0 : 1);
            repeat (3) tick();
            rd(3'd0, v); chk("R11 frozen", v, n);
            wr(3'd3, 16'h0002, 2'b01);
            rd(3'd3, v); chk("R10 clear second only", v, inh ? 16'h0000 : 16'h0004);
            tick();
            rd(3'd0, v); chk("R11 resumes", v, n - 1);
        end

        // R10 zero write leaves flags; byte enable off ignored
        rd(3'd2, v); chk("R10 first still set", v, 16'h0008);
        wr(3'd2, 16'h0000, 2'b11); rd(3'd2, v); chk("R10 write 0 keeps", v, 16'h0008);
        wr(3'd2, 16'h0008, 2'b10); rd(3'd2, v); chk("R10 be off keeps", v, 16'h0008);
        wr(3'd2, 16'h0008, 2'b01); rd(3'd2, v); chk("R10 w1c", v, 0);
        chk("R7 irq drops", irq, 0);

        // R10 set wins over same-cycle clear; R12 restart of escalation
        setup(5, 1, 0);
        repeat (4) tick();
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 16'h0008; bus_be = 2'b01; tick_en = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0; tick_en = 1'b0;
        rd(3'd2, v); chk("R10 set wins", v, 16'h0008);
        chk("R7 irq enabled", irq, 1);
        wr(3'd2, 16'h0008, 2'b01);
        p0 = pulses;
        repeat (5) tick();
        rd(3'd2, v); chk("R12 first again", v, 16'h0008);
        rd(3'd3, v); chk("R12 no second", v, 0);
        chk("R12 no pulse", pulses - p0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule